// File: doc/BRIEF.md
# Asynchronous NOR Flash Bus Front-End

This block lets an on-chip word array answer an external asynchronous parallel bus the way a NOR flash would. Three active-low strobes arrive without a clock: chip select, output enable and write enable. The block passes them through two-flop synchronizers. The address and data buses run through a delay line of the same depth, so every sample lines up with the strobe state it belongs to. A read drives the array word, or a status word while an operation is running. A write cycle feeds a small command interpreter that can program one location, erase one of four blocks, or set a lock that protects the lowest block.

A static width pin chooses 16-bit word operation or 8-bit byte operation. In byte mode only the low data lane is driven, and data line 15 becomes the least significant byte address. Program and erase are not timed as real cells are. Each accepted operation updates the array at once and then holds a busy flag for a parameterised number of clocks.

Top module: `nor_bus_front`

## Requirements
- R1: With ce_n low, oe_n low and we_n high, the block drives dq_oe to all ones in word mode, and dq_out holds the word stored at addr. Once the strobes have settled, this appears within six clocks.
- R2: When oe_n is high, dq_oe is zero from the second clock after the synchronized level is seen.
- R3: A write cycle takes its address at the moment the later of ce_n and we_n goes low.
- R4: A write cycle takes its data as it stood just before the earlier of ce_n and we_n goes high. A write cycle during which oe_n is low has no effect.
- R5: Command bytes are decoded from data bits 7:0 only, and bits 15:8 are ignored.
- R6: When byte_n is low, only dq_oe[7:0] may be set. dq_in[15] is the byte address bit: 0 selects bits 7:0 of the word and 1 selects bits 15:8. A read returns the selected byte on dq_out[7:0]. A program writes dq_in[7:0] into the selected byte only.
- R7: Word addresses split into four blocks. The boot block covers 0..BOOT_WORDS-1. Parameter block one follows with PARAM_WORDS words, then parameter block two with PARAM_WORDS words. The main block holds the rest.
- R8: After reset, busy is low, dq_oe is zero, the interpreter is idle and the boot lock is clear.
- R9: Writing 0xAA and then 0x40 sets the boot lock. While the lock is set, a program or erase aimed at the boot block changes nothing and raises no busy flag. Only reset clears the lock.
- R10: Each accepted program or erase raises busy for BUSY_CYCLES clocks. Write cycles during busy are ignored. A read during busy returns the status word, which has bit 6 equal to the lock and all other bits zero.
- R11: Writing 0xAA, then 0x80, then 0x30 at an address sets every word of that address's block to 0xFFFF and leaves all other blocks unchanged.
- R12: Writing 0xAA, then 0xA0, then a data cycle stores that data at the data cycle's address, replacing the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| byte_n | input | 1 | Width select: 1 word mode, 0 byte mode |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data bus input; bit 15 is the byte address in byte mode |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 16 | Per-line output enable for the data bus |
| busy | output | 1 | Program or erase in progress |

## Verification
On every clock, the assertions check the following. The outputs are released when the synchronized output enable is high. The upper lane is never enabled in byte mode. The lock never clears on its own. No array update happens while busy, and each update is followed by busy. No update reaches the boot block while the lock is set. Only the directed scenarios can show the rest: which strobe edge supplies the address and the data, the exact block borders touched by an erase, the byte-lane merge, and that the upper data bits do not affect command decoding. All of these depend on the data that comes back through later reads.

// File: rtl/nor_bus_pkg.sv
package nor_bus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_PROG,
        ST_ERASE
    } nor_fsm_e;

    typedef enum logic [1:0] {
        BLK_BOOT,
        BLK_PAR1,
        BLK_PAR2,
        BLK_MAIN
    } nor_blk_e;

    localparam logic [7:0] CMD_UNLOCK   = 8'hAA;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_ERASE_GO = 8'h30;
    localparam logic [7:0] CMD_LOCK     = 8'h40;

    // Block of a word address: boot at the bottom, two parameter blocks, then main.
    function automatic nor_blk_e blk_of(input int unsigned a,
                                        input int unsigned boot_words,
                                        input int unsigned param_words);
        if (a < boot_words)                        return BLK_BOOT;
        else if (a < boot_words + param_words)     return BLK_PAR1;
        else if (a < boot_words + 2 * param_words) return BLK_PAR2;
        else                                       return BLK_MAIN;
    endfunction

endpackage

// File: rtl/nor_strobe_sync.sv
module nor_strobe_sync #(
    parameter int AW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_in,
    output logic          ce_al,
    output logic          oe_al,
    output logic          we_al,
    output logic [AW-1:0] addr_al,
    output logic [15:0]   dq_al
);
    localparam int W = 3 + AW + 16;
    localparam logic [W-1:0] RST_VAL = {3'b111, {(AW + 16){1'b0}}};

    // Strobes are synchronized; buses ride the same delay so samples stay aligned.
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                stg_q[s] <= stg_q[s-1];
            end
            stg_q[0] <= {ce_n, oe_n, we_n, addr, dq_in};
        end
    end

    assign {ce_al, oe_al, we_al, addr_al, dq_al} = stg_q[STAGES-1];

endmodule

// File: rtl/nor_blk_decode.sv
module nor_blk_decode
    import nor_bus_pkg::*;
#(
    parameter int          AW          = 8,
    parameter int unsigned BOOT_WORDS  = 32,
    parameter int unsigned PARAM_WORDS = 16
) (
    input  logic [AW-1:0] addr,
    output nor_blk_e      blk
);
    assign blk = blk_of(32'(addr), BOOT_WORDS, PARAM_WORDS);
endmodule

// File: rtl/nor_array.sv
module nor_array
    import nor_bus_pkg::*;
#(
    parameter int          AW          = 8,
    parameter int unsigned BOOT_WORDS  = 32,
    parameter int unsigned PARAM_WORDS = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [1:0]    be,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic          erase,
    input  nor_blk_e      erase_blk,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0][15:0] words;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam nor_blk_e MY_BLK = blk_of(i, BOOT_WORDS, PARAM_WORDS);
        logic [15:0] word_q;

        always_ff @(posedge clk) begin
            if (erase && erase_blk == MY_BLK) begin
                word_q <= 16'hFFFF;
            end else if (we && waddr == AW'(i)) begin
                if (be[0]) word_q[7:0]  <= wdata[7:0];
                if (be[1]) word_q[15:8] <= wdata[15:8];
            end
        end

        assign words[i] = word_q;
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front
    import nor_bus_pkg::*;
#(
    parameter int          AW          = 8,
    parameter int unsigned BOOT_WORDS  = 32,
    parameter int unsigned PARAM_WORDS = 16,
    parameter int unsigned BUSY_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          byte_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_in,
    output logic [15:0]   dq_out,
    output logic [15:0]   dq_oe,
    output logic          busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        nor_fsm_e         st;
        logic             lock;
        logic [CNT_W-1:0] cnt;
        logic             act_prev;
        logic [AW-1:0]    cap_addr;
        logic             cap_lsb;
        logic [15:0]      hold_data;
        logic             hold_oe;
        logic [15:0]      rd_data;
        logic [15:0]      rd_oe;
    } state_t;

    localparam state_t RESET_STATE = '{
        st: ST_IDLE, lock: 1'b0, cnt: '0, act_prev: 1'b0,
        cap_addr: '0, cap_lsb: 1'b0, hold_data: '0, hold_oe: 1'b0,
        rd_data: '0, rd_oe: '0
    };

    state_t q, d;

    logic          ce_al, oe_al, we_al;
    logic [AW-1:0] addr_al;
    logic [15:0]   dq_al;
    nor_blk_e      wr_blk;
    logic [15:0]   arr_rdata;
    logic          arr_we, arr_erase;
    logic [1:0]    arr_be;
    logic [15:0]   arr_wdata;
    logic          lock_q;

    nor_strobe_sync #(.AW(AW), .STAGES(2)) u_sync (
        .clk, .rst_n, .ce_n, .oe_n, .we_n, .addr, .dq_in,
        .ce_al, .oe_al, .we_al, .addr_al, .dq_al
    );

    nor_blk_decode #(.AW(AW), .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS)) u_dec (
        .addr(q.cap_addr),
        .blk (wr_blk)
    );

    nor_array #(.AW(AW), .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS)) u_arr (
        .clk,
        .we       (arr_we),
        .be       (arr_be),
        .waddr    (q.cap_addr),
        .wdata    (arr_wdata),
        .erase    (arr_erase),
        .erase_blk(wr_blk),
        .raddr    (addr_al),
        .rdata    (arr_rdata)
    );

    always_comb begin
        logic        wr_act, wr_done, busy_now, rd_act, guarded;
        logic [7:0]  cmd;
        logic [15:0] word;

        d         = q;
        arr_we    = 1'b0;
        arr_erase = 1'b0;
        arr_be    = 2'b11;
        arr_wdata = q.hold_data;

        busy_now   = (q.cnt != '0);
        wr_act     = !ce_al && !we_al;
        wr_done    = q.act_prev && !wr_act;
        d.act_prev = wr_act;
        cmd        = q.hold_data[7:0];
        guarded    = q.lock && (wr_blk == BLK_BOOT);

        if (busy_now) d.cnt = q.cnt - 1'b1;

        // Address at the later falling strobe, data held until the first rising one.
        if (wr_act && !q.act_prev) begin
            d.cap_addr = addr_al;
            d.cap_lsb  = dq_al[15];
        end
        if (wr_act) begin
            d.hold_data = dq_al;
            d.hold_oe   = oe_al;
        end

        if (wr_done && q.hold_oe && !busy_now) begin
            d.st = ST_IDLE;
            unique case (q.st)
                ST_IDLE: if (cmd == CMD_UNLOCK) d.st = ST_CMD;
                ST_CMD: begin
                    if (cmd == CMD_PROGRAM)    d.st = ST_PROG;
                    else if (cmd == CMD_ERASE) d.st = ST_ERASE;
                    else if (cmd == CMD_LOCK)  d.lock = 1'b1;
                end
                ST_PROG: begin
                    if (!guarded) begin
                        arr_we = 1'b1;
                        if (!byte_n) begin
                            arr_wdata = {cmd, cmd};
                            arr_be    = q.cap_lsb ? 2'b10 : 2'b01;
                        end
                        d.cnt = CNT_W'(BUSY_CYCLES);
                    end
                end
                ST_ERASE: begin
                    if (cmd == CMD_ERASE_GO && !guarded) begin
                        arr_erase = 1'b1;
                        d.cnt     = CNT_W'(BUSY_CYCLES);
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end

        // Read path: status word replaces array data while an operation runs.
        rd_act = !ce_al && !oe_al && we_al;
        word   = busy_now ? {9'b0, q.lock, 6'b0} : arr_rdata;
        if (byte_n) begin
            d.rd_data = word;
        end else begin
            d.rd_data = {8'h00, dq_al[15] ? word[15:8] : word[7:0]};
        end
        d.rd_oe = rd_act ? (byte_n ? 16'hFFFF : 16'h00FF) : 16'h0000;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_STATE;
        else        q <= d;
    end

    assign dq_out = q.rd_data;
    assign dq_oe  = q.rd_oe;
    assign busy   = (q.cnt != '0);
    assign lock_q = q.lock;

endmodule

// File: rtl/nor_bus_checker.sv
module nor_bus_checker
    import nor_bus_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        oe_al,
    input logic        byte_n,
    input logic [15:0] dq_oe,
    input logic        busy,
    input logic        arr_we,
    input logic        arr_erase,
    input logic        lock_q,
    input nor_blk_e    wr_blk
);
    // R2
    a_r2_release_on_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        oe_al |=> (dq_oe == 16'h0000));

    // R6
    a_r6_upper_lane_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(byte_n) |-> (dq_oe[15:8] == 8'h00));

    // R9
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R9
    a_r9_boot_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && (arr_we || arr_erase)) |-> (wr_blk != BLK_BOOT));

    // R10
    a_r10_idle_when_update: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we || arr_erase) |-> !busy);

    // R10
    a_r10_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we || arr_erase) |=> busy);

endmodule

bind nor_bus_front nor_bus_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_al    (oe_al),
    .byte_n   (byte_n),
    .dq_oe    (dq_oe),
    .busy     (busy),
    .arr_we   (arr_we),
    .arr_erase(arr_erase),
    .lock_q   (lock_q),
    .wr_blk   (wr_blk)
);

// File: tb/tb_nor_bus_front.sv
module tb_nor_bus_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out, dq_oe;
    logic        busy;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    nor_bus_front #(.AW(8), .BOOT_WORDS(32), .PARAM_WORDS(16), .BUSY_CYCLES(60)) dut (
        .clk, .rst_n, .ce_n, .oe_n, .we_n, .byte_n, .addr, .dq_in, .dq_out, .dq_oe, .busy
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; dq_in = d; oe_n = 1'b1; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input logic lsb,
                      output logic [15:0] val, output logic [15:0] en);
        @(negedge clk); addr = a; dq_in = {lsb, 15'h0}; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        repeat (6) @(negedge clk);
        val = dq_out; en = dq_oe;
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic program_word(input logic [7:0] a, input logic [15:0] d);
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h00A0); wr(a, d); wait_idle();
    endtask

    task automatic erase_block(input logic [7:0] a);
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h0080); wr(a, 16'h0030); wait_idle();
    endtask

    task automatic expect_word(input string req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] v, e;
        rd(a, 1'b0, v, e);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        check("R8 busy after reset", {15'h0, busy}, 16'h0000);
        check("R8 dq_oe after reset", dq_oe, 16'h0000);
    endtask

    task automatic t_word_prog();
        logic [15:0] v, e;
        program_word(8'h70, 16'hBEEF);
        rd(8'h70, 1'b0, v, e);
        check("R12 programmed word", v, 16'hBEEF);
        check("R1 word-mode enables", e, 16'hFFFF);
        check("R2 released after oe_n high", dq_oe, 16'h0000);
        program_word(8'h70, 16'h0123);
        expect_word("R12 overwrite", 8'h70, 16'h0123);
    endtask

    task automatic t_upper_ignored();
        wr(8'h00, 16'h5AAA); wr(8'h00, 16'hC3A0); wr(8'h71, 16'h1234); wait_idle();
        expect_word("R5 upper bits ignored", 8'h71, 16'h1234);
    endtask

    task automatic split_write(input logic we_first, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); addr = 8'h10; dq_in = d; oe_n = 1'b1;
        if (we_first) we_n = 1'b0; else ce_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = a;
        if (we_first) ce_n = 1'b0; else we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_addr_last_fall();
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h00A0); split_write(1'b0, 8'h72, 16'h4321); wait_idle();
        expect_word("R3 we_n fell last", 8'h72, 16'h4321);
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h00A0); split_write(1'b1, 8'h73, 16'h8765); wait_idle();
        expect_word("R3 ce_n fell last", 8'h73, 16'h8765);
    endtask

    task automatic t_data_first_rise();
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h00A0);
        @(negedge clk); addr = 8'h74; dq_in = 16'h1111; oe_n = 1'b1; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1; dq_in = 16'h2222;
        repeat (2) @(negedge clk); ce_n = 1'b1;
        repeat (4) @(negedge clk); wait_idle();
        expect_word("R4 data at we_n rise", 8'h74, 16'h1111);
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h00A0);
        @(negedge clk); addr = 8'h75; dq_in = 16'h3333; oe_n = 1'b1; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1; dq_in = 16'h4444;
        repeat (2) @(negedge clk); we_n = 1'b1;
        repeat (4) @(negedge clk); wait_idle();
        expect_word("R4 data at ce_n rise", 8'h75, 16'h3333);
    endtask

    task automatic t_oe_low_ignored();
        program_word(8'h76, 16'h0F0F);
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h00A0);
        @(negedge clk); addr = 8'h76; dq_in = 16'hAAAA; oe_n = 1'b0; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk); oe_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 oe_n-low write no busy", {15'h0, busy}, 16'h0000);
        expect_word("R4 oe_n-low write ignored", 8'h76, 16'h0F0F);
        wr(8'h76, 16'h6666); wait_idle();
        expect_word("R4 sequence continues", 8'h76, 16'h6666);
    endtask

    task automatic t_byte_mode();
        logic [15:0] v, e;
        program_word(8'h77, 16'h1234);
        byte_n = 1'b0;
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h00A0); wr(8'h77, 16'h809C); wait_idle();
        rd(8'h77, 1'b0, v, e);
        check("R6 low byte", v, 16'h0034);
        check("R6 byte-mode enables", e, 16'h00FF);
        rd(8'h77, 1'b1, v, e);
        check("R6 programmed high byte", v, 16'h009C);
        byte_n = 1'b1;
        expect_word("R6 merged word", 8'h77, 16'h9C34);
    endtask

    task automatic t_erase_blocks();
        program_word(8'd31, 16'h0101); program_word(8'd32, 16'h0202);
        program_word(8'd47, 16'h0303); program_word(8'd48, 16'h0404);
        program_word(8'd63, 16'h0505); program_word(8'd64, 16'h0606);
        program_word(8'd200, 16'h0707);
        erase_block(8'd40);
        expect_word("R11 par1 first word", 8'd32, 16'hFFFF);
        expect_word("R11 par1 last word", 8'd47, 16'hFFFF);
        expect_word("R7 boot top untouched", 8'd31, 16'h0101);
        expect_word("R7 par2 base untouched", 8'd48, 16'h0404);
        erase_block(8'd200);
        expect_word("R11 main base", 8'd64, 16'hFFFF);
        expect_word("R11 main word", 8'd200, 16'hFFFF);
        expect_word("R7 par2 top untouched", 8'd63, 16'h0505);
    endtask

    task automatic t_busy_status();
        logic [15:0] v, e;
        program_word(8'h78, 16'h0000);
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h00A0); wr(8'h79, 16'h7777);
        check("R10 busy raised", {15'h0, busy}, 16'h0001);
        rd(8'h79, 1'b0, v, e);
        check("R10 status while busy", v, 16'h0000);
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h00A0); wr(8'h78, 16'h8888);
        wait_idle();
        expect_word("R10 write during busy ignored", 8'h78, 16'h0000);
        expect_word("R10 program completed", 8'h79, 16'h7777);
    endtask

    task automatic t_lock();
        logic [15:0] v, e;
        program_word(8'h05, 16'hABCD);
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h0040);
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h00A0); wr(8'h05, 16'h0000);
        check("R9 locked program no busy", {15'h0, busy}, 16'h0000);
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h0080); wr(8'h05, 16'h0030);
        check("R9 locked erase no busy", {15'h0, busy}, 16'h0000);
        expect_word("R9 boot data unchanged", 8'h05, 16'hABCD);
        wr(8'h00, 16'h00AA); wr(8'h00, 16'h00A0); wr(8'h7A, 16'h3C3C);
        rd(8'h7A, 1'b0, v, e);
        check("R10 status shows lock", v, 16'h0040);
        wait_idle();
        expect_word("R9 other block writable", 8'h7A, 16'h3C3C);
    endtask

    task automatic t_reset_clears_lock();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 busy low after second reset", {15'h0, busy}, 16'h0000);
        program_word(8'h05, 16'h1357);
        expect_word("R9 lock cleared by reset", 8'h05, 16'h1357);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        fork
            begin
                t_reset();
                t_word_prog();
                t_upper_ignored();
                t_addr_last_fall();
                t_data_first_rise();
                t_oe_low_ignored();
                t_byte_mode();
                t_erase_blocks();
                t_busy_status();
                t_lock();
                t_reset_clears_lock();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule